// File: doc/BRIEF.md
# Radix-4 Digit-Select Multiplier

This block multiplies an unsigned multiplicand by an unsigned multiplier. It does not form one bit product for every multiplier bit. It cuts the multiplier into two-bit digits. For each digit it picks one of four ready-made multiples of the multiplicand: zero, single, double or triple. The triple multiple is formed once per operation and is shared by every digit slice.

Each digit drives a small decoder with one output for each nonzero digit value. An AND/OR selection cell uses those outputs to gate exactly one multiple onto the partial-product lane. Neighbouring lanes are summed in pairs, and a register holds these pair sums. A second adder level then weights each pair sum by its power of four and forms the full product in an output register. The block accepts a new operation on every clock.

Top module: `pp2_multiplier`

## Requirements
- R1: While `rst_n` is low, and at the first check after reset is released, `out_vld` is 0 and `product` is 0.
- R2: For every accepted operation, `product` equals `mcand * mplier` as an unsigned value, 24 bits wide with the default widths.
- R3: An operation presented with `in_vld` high and sampled at rising edge k has its result on `product`, with `out_vld` high, after rising edge k+1. The result is visible from that edge until the next one.
- R4: Operations may be accepted on consecutive clocks. Results come out one per clock, in the order they were accepted, with no bubbles.
- R5: A cycle with `in_vld` low produces no result: two edges later `out_vld` is 0, and `product` keeps the last value it produced.
- R6: A multiplier digit of value 0 (bits 2j+1:2j equal to 00) adds nothing to the product. An all-zero multiplier gives a product of 0 for any multiplicand.
- R7: The digit value 3 (bits 11) uses the triple multiple. With all digits 11 and the largest multiplicand, the product is exact: 0xFFFF * 0xFF = 0xFEFF01.
- R8: Digit j (multiplier bits 2j+1:2j) carries weight 4^j. A multiplier with a single nonzero digit d at position j gives `mcand * d * 4^j`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operands on this cycle are to be multiplied |
| mcand | input | 16 | Unsigned multiplicand |
| mplier | input | 8 | Unsigned multiplier, cut into 2-bit digits |
| out_vld | output | 1 | `product` holds a new result |
| product | output | 24 | Unsigned product |

## Verification
The assertions check on every cycle that each lane's partial product equals the multiplicand times that lane's digit. They also check that a zero digit gives a zero lane, that at most one decoder output is active, and that the valid flag moves through both pipeline stages. They check that a valid output equals the product of the operands from two edges earlier, and that `product` holds still when no result is due. Only the bench scenarios can show behaviour over a sequence: an exhaustive back-to-back sweep of the multiplier with no bubbles, results held across gaps in the input stream, the reset values, and exact results at the extreme operands.

// File: rtl/pp2_multiplier.sv
module pp2_multiplier #(
  parameter int WW = 16,
  parameter int LW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [WW-1:0]     mcand,
  input  logic [LW-1:0]     mplier,
  output logic              out_vld,
  output logic [WW+LW-1:0]  product
);
  // LW must be a multiple of 4 so that digit lanes pair up evenly
  localparam int ND    = LW / 2;
  localparam int NPAIR = ND / 2;
  localparam int PPW   = WW + 2;
  localparam int PRW   = WW + 4;
  localparam int PW    = WW + LW;

  logic [PPW-1:0] m1, m2, m3;
  assign m1 = {2'b00, mcand};
  assign m2 = {1'b0, mcand, 1'b0};
  assign m3 = m1 + m2;

  logic [2:0]     dec  [ND];
  logic [PPW-1:0] pp   [ND];
  logic [PRW-1:0] pair [NPAIR];

  for (genvar j = 0; j < ND; j++) begin : g_lane
    logic [1:0] dig;
    assign dig    = mplier[2*j +: 2];
    assign dec[j] = {dig == 2'd3, dig == 2'd2, dig == 2'd1};
    assign pp[j]  = ({PPW{dec[j][0]}} & m1) |
                    ({PPW{dec[j][1]}} & m2) |
                    ({PPW{dec[j][2]}} & m3);

    assert_dec_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dec[j]));
    assert_zero_digit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dig == 2'd0) |-> (pp[j] == '0));
    assert_lane_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pp[j] == PPW'(PPW'(mcand) * PPW'(dig)));
  end

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign pair[i] = PRW'(pp[2*i]) + (PRW'(pp[2*i+1]) << 2);
  end

  logic           s1_vld;
  logic [PRW-1:0] s1_pair [NPAIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      for (int i = 0; i < NPAIR; i++) s1_pair[i] <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld)
        for (int i = 0; i < NPAIR; i++) s1_pair[i] <= pair[i];
    end
  end

  logic [PW-1:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < NPAIR; i++) acc = acc + (PW'(s1_pair[i]) << (4*i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      product <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) product <= acc;
    end
  end

  assert_stage1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> s1_vld);
  assert_stage2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_vld);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> (!out_vld && $stable(product)));
  assert_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (product == PW'(PW'($past(mcand, 2)) * PW'($past(mplier, 2)))));
endmodule

// File: tb/pp2_multiplier_bench.sv
`timescale 1ns/1ps
module pp2_multiplier_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [15:0] mcand = '0;
  logic [7:0]  mplier = '0;
  logic        out_vld;
  logic [23:0] product;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pp2_multiplier u_pp2_multiplier (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mcand(mcand),
    .mplier(mplier), .out_vld(out_vld), .product(product));

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation, checked after the second edge
  task automatic single(string req, logic [15:0] a, logic [7:0] b);
    @(negedge clk);
    mcand = a; mplier = b; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    chk({req, " vld"}, {23'd0, out_vld}, 24'd1);
    chk(req, product, 24'(a) * 24'(b));
  endtask

  task automatic t_reset;
    chk("R1 vld in reset", {23'd0, out_vld}, 24'd0);
    chk("R1 product in reset", product, 24'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vld after reset", {23'd0, out_vld}, 24'd0);
    chk("R1 product after reset", product, 24'd0);
  endtask

  task automatic t_sweep;
    logic [23:0] exp_q [256];
    for (int i = 0; i < 258; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R4 vld stream", {23'd0, out_vld}, 24'd1);
        chk("R2 sweep", product, exp_q[i-2]);
      end
      if (i < 256) begin
        mcand = 16'($urandom); mplier = 8'(i); in_vld = 1'b1;
        exp_q[i] = 24'(mcand) * 24'(i);
      end else begin
        in_vld = 1'b0;
      end
    end
  endtask

  task automatic t_digits;
    for (int j = 0; j < 4; j++)
      for (int d = 1; d < 4; d++)
        single("R8 single digit", 16'hB3C5, 8'(d << (2*j)));
    single("R6 zero multiplier", 16'hFFFF, 8'h00);
    single("R6 zero digits", 16'h1234, 8'h41);
  endtask

  task automatic t_max;
    single("R7 max", 16'hFFFF, 8'hFF);
    chk("R7 constant", product, 24'hFEFF01);
    single("R7 triple", 16'h8001, 8'hC3);
  endtask

  task automatic t_gap;
    logic [23:0] held;
    single("R3 latency", 16'h0F0F, 8'h9A);
    held = product;
    @(negedge clk);
    mcand = 16'hFFFF; mplier = 8'hFF; in_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 no valid", {23'd0, out_vld}, 24'd0);
    chk("R5 product held", product, held);
    @(negedge clk);
    mcand = 16'd7; mplier = 8'd9; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    chk("R3 not early", {23'd0, out_vld}, 24'd0);
    @(negedge clk);
    chk("R3 on time", product, 24'd63);
  endtask

  initial begin
    t_reset;
    t_sweep;
    t_digits;
    t_max;
    t_gap;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule